// File: doc/BRIEF.md
# Keyed Flash Command Launcher

This block sits between a peripheral register bus and a flash programming engine. Software starts a flash operation with a single 16-bit write to a control register. That write carries an unlock key in the upper byte and a seven-bit operation code in the low bits. The block checks the key and checks that the code is a known operation. It also applies the rules for the non-secure register alias. An accepted operation is held until the main memory bus and the flash array are both idle. The block then sends the operation code, together with the current address register, to the engine as a one-cycle strobe.

A ready bit shows whether the engine can take a new operation. Two sticky error flags record a bad key and a refused operation. Software clears each flag by writing a 1 to its bit in a flag-clear register. The non-secure address boundary and the non-secure write permission come in as inputs from surrounding configuration logic.

Top module: `flash_cmd_launcher`

## Requirements
- R1: After reset, `ready` is 1, `key_err` and `prog_err` are 0, and `cmd_strobe` is 0.
- R2: The control register is selected by `wr_sel`=0. Its bits 15:8 hold the key and bits 6:0 hold the operation code. Bit 7 is ignored. A write whose key is not 0xA5 sets `key_err` and launches nothing.
- R3: A control write is accepted when the key is 0xA5, the code is valid and `ready` is 1. If both busy inputs are low, `cmd_strobe` is 1 for exactly one cycle, one clock after the write edge. In that cycle `cmd_code` carries the code and `cmd_addr` carries the address register.
- R4: The valid codes are 0x02 (erase row), 0x04 (write page), 0x42 and 0x43 (power-reduction set and clear), 0x44 (clear page buffer), 0x46 (invalidate cache), 0x4B (debug level 0) and 0x4C (debug level 1). Any other code with a correct key sets `prog_err` and launches nothing.
- R5: A keyed control write made while an accepted operation is still pending, or while `ready` is 0, sets `prog_err`. It does not add a launch.
- R6: An accepted operation does not launch in any cycle in which `mainbus_busy` or `array_busy` is 1. It launches at the first clock edge at which both are 0.
- R7: `ready` goes to 0 on the same edge that raises `cmd_strobe`. It returns to 1 on the edge after `eng_done` is sampled high.
- R8: Through the non-secure alias (`wr_nonsec`=1), only codes 0x02, 0x04, 0x44 and 0x4B are allowed. Any other valid code sets `prog_err` and launches nothing.
- R9: A non-secure 0x02, 0x04 or 0x44 whose address register is below `ns_boundary` sets `prog_err` and launches nothing. Non-secure 0x4B does not depend on the address.
- R10: A non-secure control write while `ns_wr_allow` is 0 is ignored: neither flag changes and nothing launches.
- R11: The flags stay set until a write to `wr_sel`=2 with bit 0 set (clears `key_err`) or bit 1 set (clears `prog_err`).
- R12: A write to `wr_sel`=1 loads the address register from `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 address, 2 flag clear |
| wr_data | input | 16 | Write data |
| wr_nonsec | input | 1 | Write arrives through the non-secure alias |
| ns_wr_allow | input | 1 | Non-secure control writes permitted |
| ns_boundary | input | 16 | Lowest non-secure address |
| mainbus_busy | input | 1 | Main memory bus access this cycle |
| array_busy | input | 1 | Flash array busy |
| eng_done | input | 1 | Engine completion pulse |
| cmd_strobe | output | 1 | One-cycle launch strobe |
| cmd_code | output | 7 | Launched operation code |
| cmd_addr | output | 16 | Launched flash address |
| ready | output | 1 | Engine can accept an operation |
| key_err | output | 1 | Sticky bad-key flag |
| prog_err | output | 1 | Sticky refused-operation flag |

## Verification
The hardest condition to reach is a second keyed write that arrives while an accepted operation is still held back by bus traffic. At that point `ready` still reads 1, yet the write must be refused. The bench holds `mainbus_busy` high, writes a valid operation, and writes again before releasing the bus. It then checks that `prog_err` is set and that exactly one strobe follows. Random rounds mix keys, codes, alias, permission and addresses around the boundary, and a bench function gives the expected outcome of each round.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'hA5;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_FLAGS = 2'd2
  } reg_sel_t;

  typedef enum logic [6:0] {
    OP_ERASE_ROW  = 7'h02,
    OP_WRITE_PAGE = 7'h04,
    OP_PWR_SET    = 7'h42,
    OP_PWR_CLR    = 7'h43,
    OP_BUF_CLEAR  = 7'h44,
    OP_CACHE_INV  = 7'h46,
    OP_DBG_LVL0   = 7'h4B,
    OP_DBG_LVL1   = 7'h4C
  } op_code_t;
endpackage

// File: rtl/fcl_decode.sv
module fcl_decode #(
  parameter int AW = 16,
  parameter int CW = 7
) (
  input  logic [CW-1:0] code,
  input  logic          nonsec,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] boundary,
  output logic          permitted
);
  import fcl_pkg::*;

  logic known, ns_listed, addr_bound, addr_ok;

  always_comb begin
    known      = 1'b0;
    ns_listed  = 1'b0;
    addr_bound = 1'b0;
    case (code)
      OP_ERASE_ROW, OP_WRITE_PAGE, OP_BUF_CLEAR: begin
        known = 1'b1; ns_listed = 1'b1; addr_bound = 1'b1;
      end
      OP_DBG_LVL0: begin
        known = 1'b1; ns_listed = 1'b1;
      end
      OP_PWR_SET, OP_PWR_CLR, OP_CACHE_INV, OP_DBG_LVL1: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign addr_ok   = !addr_bound || (addr >= boundary);
  assign permitted = known && (!nonsec || (ns_listed && addr_ok));
endmodule

// File: rtl/fcl_regs.sv
module fcl_regs #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_wr,
  input  logic          flag_wr,
  input  logic [DW-1:0] wdata,
  input  logic          set_key,
  input  logic          set_prog,
  output logic [AW-1:0] addr_q,
  output logic          key_err,
  output logic          prog_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      key_err  <= 1'b0;
      prog_err <= 1'b0;
    end else begin
      if (addr_wr) addr_q <= wdata[AW-1:0];
      if (set_key) key_err <= 1'b1;
      else if (flag_wr && wdata[0]) key_err <= 1'b0;
      if (set_prog) prog_err <= 1'b1;
      else if (flag_wr && wdata[1]) prog_err <= 1'b0;
    end
  end
endmodule

// File: rtl/fcl_launch.sv
module fcl_launch #(
  parameter int AW = 16,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [CW-1:0] new_code,
  input  logic [AW-1:0] addr_q,
  input  logic          mainbus_busy,
  input  logic          array_busy,
  input  logic          eng_done,
  output logic          pending,
  output logic          ready,
  output logic          cmd_strobe,
  output logic [CW-1:0] cmd_code,
  output logic [AW-1:0] cmd_addr
);
  logic [CW-1:0] held_code;
  logic          go;

  assign go = pending && !mainbus_busy && !array_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      held_code  <= '0;
      ready      <= 1'b1;
      cmd_strobe <= 1'b0;
      cmd_code   <= '0;
      cmd_addr   <= '0;
    end else begin
      cmd_strobe <= 1'b0;
      if (accept) begin
        pending   <= 1'b1;
        held_code <= new_code;
      end
      if (go) begin
        pending    <= 1'b0;
        cmd_strobe <= 1'b1;
        ready      <= 1'b0;
        cmd_code   <= held_code;
        cmd_addr   <= addr_q;
      end else if (eng_done && !ready) begin
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_launcher.sv
module flash_cmd_launcher #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_nonsec,
  input  logic          ns_wr_allow,
  input  logic [AW-1:0] ns_boundary,
  input  logic          mainbus_busy,
  input  logic          array_busy,
  input  logic          eng_done,
  output logic          cmd_strobe,
  output logic [CW-1:0] cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic          ready,
  output logic          key_err,
  output logic          prog_err
);
  import fcl_pkg::*;

  localparam int KEY_LSB = DW - 8;

  logic          ctrl_wr, addr_wr, flag_wr;
  logic          key_ok, permitted, in_progress, pending;
  logic          accept, set_key, set_prog;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] wr_code;

  assign wr_code = wr_data[CW-1:0];
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL) && (!wr_nonsec || ns_wr_allow);
  assign addr_wr = wr_en && (wr_sel == SEL_ADDR);
  assign flag_wr = wr_en && (wr_sel == SEL_FLAGS);
  assign key_ok  = (wr_data[DW-1:KEY_LSB] == UNLOCK_KEY);
  assign in_progress = pending || !ready;

  assign accept   = ctrl_wr && key_ok && permitted && !in_progress;
  assign set_key  = ctrl_wr && !key_ok;
  assign set_prog = ctrl_wr && key_ok && !accept;

  fcl_decode #(.AW(AW), .CW(CW)) u_decode (
    .code(wr_code), .nonsec(wr_nonsec), .addr(addr_q),
    .boundary(ns_boundary), .permitted(permitted)
  );

  fcl_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .flag_wr(flag_wr),
    .wdata(wr_data), .set_key(set_key), .set_prog(set_prog),
    .addr_q(addr_q), .key_err(key_err), .prog_err(prog_err)
  );

  fcl_launch #(.AW(AW), .CW(CW)) u_launch (
    .clk(clk), .rst(rst), .accept(accept), .new_code(wr_code),
    .addr_q(addr_q), .mainbus_busy(mainbus_busy), .array_busy(array_busy),
    .eng_done(eng_done), .pending(pending), .ready(ready),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_addr(cmd_addr)
  );
endmodule

module flash_cmd_launcher_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [DW-1:0] wr_data,
  input logic          mainbus_busy,
  input logic          array_busy,
  input logic          eng_done,
  input logic          cmd_strobe,
  input logic          ready,
  input logic          key_err,
  input logic          prog_err
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |=> !cmd_strobe); // R3
  AST_NO_LAUNCH_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> $past(!mainbus_busy && !array_busy)); // R6
  AST_READY_LOW_AT_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> !ready); // R7
  AST_READY_BACK_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(eng_done)); // R7
  AST_KEYERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (key_err && !(wr_en && wr_sel == 2'd2 && wr_data[0])) |=> key_err); // R11
  AST_PROGERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (prog_err && !(wr_en && wr_sel == 2'd2 && wr_data[1])) |=> prog_err); // R11
endmodule

bind flash_cmd_launcher flash_cmd_launcher_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .mainbus_busy(mainbus_busy), .array_busy(array_busy), .eng_done(eng_done),
  .cmd_strobe(cmd_strobe), .ready(ready), .key_err(key_err), .prog_err(prog_err)
);

// File: tb/tb_flash_cmd_launcher.sv
module tb_flash_cmd_launcher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        wr_nonsec = 1'b0;
  logic        ns_wr_allow = 1'b1;
  logic [15:0] ns_boundary = 16'h8000;
  logic        mainbus_busy = 1'b0;
  logic        array_busy = 1'b0;
  logic        eng_done = 1'b0;
  logic        cmd_strobe, ready, key_err, prog_err;
  logic [6:0]  cmd_code;
  logic [15:0] cmd_addr;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done_flag = 1'b0;

  localparam int O_IGN = 0, O_KEY = 1, O_PROG = 2, O_GO = 3;

  always #4 clk = ~clk;

  flash_cmd_launcher dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_nonsec(wr_nonsec), .ns_wr_allow(ns_wr_allow), .ns_boundary(ns_boundary),
    .mainbus_busy(mainbus_busy), .array_busy(array_busy), .eng_done(eng_done),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .ready(ready), .key_err(key_err), .prog_err(prog_err)
  );

  function automatic bit known_op(input logic [6:0] c);
    return c == 7'h02 || c == 7'h04 || c == 7'h42 || c == 7'h43 ||
           c == 7'h44 || c == 7'h46 || c == 7'h4B || c == 7'h4C;
  endfunction

  function automatic int expect_outcome(input logic [7:0] key, input logic [6:0] c,
      input bit ns, input bit allow, input logic [15:0] a, input logic [15:0] bnd);
    if (ns && !allow) return O_IGN;
    if (key != 8'hA5) return O_KEY;
    if (!known_op(c)) return O_PROG;
    if (ns) begin
      if (!(c == 7'h02 || c == 7'h04 || c == 7'h44 || c == 7'h4B)) return O_PROG;
      if (c != 7'h4B && a < bnd) return O_PROG;
    end
    return O_GO;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d, input bit ns);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_nonsec = ns;
    @(negedge clk);
    wr_en = 1'b0; wr_nonsec = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    check("R7 ready after done", ready, 1);
  endtask

  task automatic clear_flags();
    wr(2'd2, 16'h0003, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  k;
    logic [6:0]  c;
    bit          ns, allow;
    int          o;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", ready, 1);
    check("R1 key_err", key_err, 0);
    check("R1 prog_err", prog_err, 0);
    check("R1 strobe", cmd_strobe, 0);

    // R12 address load, R3 basic launch with bit 7 set (ignored per R2)
    wr(2'd1, 16'h9ABC, 1'b0);
    wr(2'd0, 16'hA584, 1'b0);
    check("R3 no strobe on write edge", cmd_strobe, 0);
    @(negedge clk);
    check("R3 strobe", cmd_strobe, 1);
    check("R3 code", cmd_code, 7'h04);
    check("R12 addr", cmd_addr, 16'h9ABC);
    check("R7 ready low", ready, 0);
    @(negedge clk);
    check("R3 strobe one cycle", cmd_strobe, 0);
    // R5 write while not ready
    wr(2'd0, 16'hA502, 1'b0);
    check("R5 prog_err busy", prog_err, 1);
    @(negedge clk);
    check("R5 no launch", cmd_strobe, 0);
    finish_op();
    clear_flags();
    check("R11 cleared", prog_err, 0);

    // R2 bad key, R11 sticky
    wr(2'd0, 16'h5A02, 1'b0);
    check("R2 key_err", key_err, 1);
    @(negedge clk);
    check("R2 no launch", cmd_strobe, 0);
    wr(2'd2, 16'h0002, 1'b0);
    check("R11 key_err kept", key_err, 1);
    wr(2'd2, 16'h0001, 1'b0);
    check("R11 key_err cleared", key_err, 0);

    // R4 reserved
    wr(2'd0, 16'hA545, 1'b0);
    check("R4 prog_err", prog_err, 1);
    @(negedge clk);
    check("R4 no launch", cmd_strobe, 0);
    clear_flags();

    // R6 deferral plus R5 during pending
    mainbus_busy = 1'b1;
    wr(2'd0, 16'hA546, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check("R6 held by main bus", cmd_strobe, 0);
    end
    wr(2'd0, 16'hA544, 1'b0);
    check("R5 prog_err while pending", prog_err, 1);
    array_busy = 1'b1;
    mainbus_busy = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check("R6 held by array", cmd_strobe, 0);
    end
    array_busy = 1'b0;
    @(negedge clk);
    check("R6 launch after idle", cmd_strobe, 1);
    check("R6 code", cmd_code, 7'h46);
    @(negedge clk);
    check("R5 single launch", cmd_strobe, 0);
    finish_op();
    clear_flags();

    // R8, R9, R10 directed
    ns_boundary = 16'h8000;
    wr(2'd1, 16'h7FFF, 1'b0);
    wr(2'd0, 16'hA502, 1'b1);
    check("R9 below boundary", prog_err, 1);
    clear_flags();
    wr(2'd0, 16'hA542, 1'b1);
    check("R8 not in ns list", prog_err, 1);
    clear_flags();
    ns_wr_allow = 1'b0;
    wr(2'd0, 16'h1142, 1'b1);
    check("R10 no key_err", key_err, 0);
    @(negedge clk);
    check("R10 no launch", cmd_strobe, 0);
    ns_wr_allow = 1'b1;
    wr(2'd1, 16'h8000, 1'b0);
    wr(2'd0, 16'hA502, 1'b1);
    @(negedge clk);
    check("R9 at boundary launches", cmd_strobe, 1);
    finish_op();

    // random rounds
    for (int i = 0; i < 300; i++) begin
      a = 16'($urandom);
      k = ($urandom % 4 != 0) ? 8'hA5 : 8'($urandom);
      c = ($urandom % 4 != 0) ? 7'($urandom % 2 ? 7'h02 + 7'(2 * ($urandom % 2)) : 7'h42 + 7'($urandom % 11))
                              : 7'($urandom);
      ns = 1'($urandom);
      allow = ($urandom % 4) != 0;
      ns_wr_allow = allow;
      o = expect_outcome(k, c, ns, allow, a, ns_boundary);
      wr(2'd1, a, 1'b0);
      wr(2'd0, {k, 1'($urandom), c}, ns);
      check("R2 random key_err", key_err, o == O_KEY);
      check("R8 random prog_err", prog_err, o == O_PROG);
      @(negedge clk);
      check("R3 random strobe", cmd_strobe, o == O_GO);
      if (o == O_GO) begin
        check("R3 random code", cmd_code, c);
        check("R12 random addr", cmd_addr, a);
        finish_op();
      end
      clear_flags();
    end
    ns_wr_allow = 1'b1;
    done_flag = 1'b1;
    summary();
  end
endmodule